// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a serial engine and a host register port. It holds a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Each queue has a level count and a host-programmable threshold. The block also builds a five-bit status word and a five-bit interrupt set. The interrupt set has a raw view, a mask and a masked view, and it drives one combined interrupt line.

The host side is a single-cycle register port. A write to the transmit data address pushes a word. A read of the receive data address returns the head word and pops it at the same clock edge. The engine takes transmit words over a valid/ready stream. It offers received words with a valid strobe and no back-pressure: a word that finds the receive queue full is lost, and the loss is flagged. Error flags stay set until the host clears them. The two threshold events follow the queue levels on every cycle.

Top module: `spi_fifo_status_irq`

## Requirements
- R1: After reset both levels, the thresholds, the mask and all error flags are zero, the status word reads 0x0C, the raw interrupt word reads 0x01 and the interrupt line is low.
- R2: Words written to the transmit data address leave on tx_data in write order. tx_valid is high while the transmit queue is non-empty, a word leaves when tx_valid and tx_ready are both high, and the transmit level register reports the entry count.
- R3: A write to the transmit data address while the transmit queue holds DEPTH entries is dropped, and it sets the transmit overflow flag (interrupt bit 1).
- R4: Each rx_valid cycle stores rx_data in the receive queue. A read of the receive data address returns the oldest word and removes it, and the receive level register reports the entry count.
- R5: A read of the receive data address while the receive queue is empty returns zero and sets the receive underflow flag (interrupt bit 2).
- R6: An rx_valid word that arrives while the receive queue holds DEPTH entries is discarded, and it sets the receive overflow flag (interrupt bit 3).
- R7: Status word: bit 0 busy (eng_busy or a non-empty transmit queue), bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R8: A threshold write of a value no greater than DEPTH-1 is kept. A larger value leaves the register unchanged, so a read-back returns the earlier value.
- R9: Raw interrupt bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is above the receive threshold. Both are recomputed every cycle.
- R10: A write to the clear address with bit 0 set clears all three error flags. Bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. An error event in the same cycle as its clear leaves the flag set.
- R11: The masked view equals the raw word ANDed with the mask register, and irq is high exactly when the masked view is non-zero.
- R12: Register addresses on reg_addr: 0 transmit data (write), 1 receive data (read), 2 transmit threshold, 3 receive threshold, 4 transmit level, 5 receive level, 6 status, 7 mask, 8 raw interrupts, 9 masked interrupts, 10 clear (write). Reads of write-only or unused addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, combinational from reg_addr |
| tx_valid | output | 1 | Transmit word available to the engine |
| tx_data | output | DW | Transmit head word |
| tx_ready | input | 1 | Engine takes the transmit head word |
| rx_valid | input | 1 | Engine delivers a received word |
| rx_data | input | DW | Received word |
| eng_busy | input | 1 | Engine is shifting |
| irq | output | 1 | Combined interrupt line |

## Verification
A wrong read or write pointer shows up at tx_data, or at the next receive data read, on the first pop that follows. The reference queues in the bench catch it in that cycle. A level counter that drifts shows up at once in tx_valid and in threshold bits 0 and 4. Those bits reach irq in the same cycle through the mask, so any cycle with the mask set exposes the fault. A sticky flag that is lost or set by mistake is seen one cycle after the event or the clear, through the raw view, the masked view and the interrupt line.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

   typedef enum logic [3:0] {
      A_TXDATA  = 4'd0,
      A_RXDATA  = 4'd1,
      A_TXTHR   = 4'd2,
      A_RXTHR   = 4'd3,
      A_TXLVL   = 4'd4,
      A_RXLVL   = 4'd5,
      A_STAT    = 4'd6,
      A_MASK    = 4'd7,
      A_RAW     = 4'd8,
      A_MSKSTAT = 4'd9,
      A_CLR     = 4'd10
   } sfi_addr_e;

   localparam int NIRQ       = 5;
   localparam int IRQ_TXLOW  = 0;
   localparam int IRQ_TXOVF  = 1;
   localparam int IRQ_RXUND  = 2;
   localparam int IRQ_RXOVF  = 3;
   localparam int IRQ_RXHIGH = 4;

   localparam int CLR_ALL    = 0;
   localparam int CLR_RXUND  = 1;
   localparam int CLR_RXOVF  = 2;
   localparam int CLR_TXOVF  = 3;

   localparam int NERR       = 3;

endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [LW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push) wptr <= wptr + AW'(1);
         if (pop)  rptr <= rptr + AW'(1);
         cnt <= cnt + LW'(push) - LW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_data;
   end

   assign head  = mem[rptr];
   assign level = cnt;
   assign full  = (cnt == LW'(DEPTH));
   assign empty = (cnt == '0);

endmodule

// File: rtl/sfi_irq.sv
module sfi_irq
   import sfi_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NERR-1:0] err_set,
   input  logic            clr_wr,
   input  logic [3:0]      clr_bits,
   input  logic [1:0]      lvl_evt,
   input  logic            mask_wr,
   input  logic [NIRQ-1:0] mask_in,
   output logic [NIRQ-1:0] raw,
   output logic [NIRQ-1:0] masked,
   output logic [NIRQ-1:0] mask_q,
   output logic            irq
);

   logic [NERR-1:0] flag;

   for (genvar e = 0; e < NERR; e++) begin : g_err
      localparam int CI = (e == 0) ? CLR_TXOVF :
                          (e == 1) ? CLR_RXUND : CLR_RXOVF;
      logic drop;
      assign drop = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CI]);
      always_ff @(posedge clk) begin
         if (!rst_n) flag[e] <= 1'b0;
         else        flag[e] <= err_set[e] || (flag[e] && !drop);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_in;
   end

   always_comb begin
      raw             = '0;
      raw[IRQ_TXLOW]  = lvl_evt[0];
      raw[IRQ_TXOVF]  = flag[0];
      raw[IRQ_RXUND]  = flag[1];
      raw[IRQ_RXOVF]  = flag[2];
      raw[IRQ_RXHIGH] = lvl_evt[1];
   end

   assign masked = raw & mask_q;
   assign irq    = |masked;

endmodule

// File: rtl/spi_fifo_status_irq.sv
module spi_fifo_status_irq
   import sfi_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [3:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          tx_valid,
   output logic [DW-1:0] tx_data,
   input  logic          tx_ready,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          eng_busy,
   output logic          irq
);

   if (DEPTH < 2 || DEPTH > 32 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfi: DEPTH must be a power of two from 2 to 32");
   end
   if (DW < 8) begin : g_bad_width
      $error("sfi: DW must be at least 8");
   end

   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic [LW-1:0] tx_lvl, rx_lvl;
   logic [DW-1:0] rx_head;
   logic          wr_tx, rd_rx, tx_push, tx_pop, rx_push, rx_pop;
   logic [AW-1:0] tx_thr, rx_thr;
   logic          thr_ok;
   logic [NIRQ-1:0] irq_raw, irq_msk, irq_mask;
   logic [4:0]    status;

   assign wr_tx   = reg_wr && (reg_addr == A_TXDATA);
   assign rd_rx   = reg_rd && (reg_addr == A_RXDATA);
   assign tx_push = wr_tx && !tx_full;
   assign tx_pop  = tx_valid && tx_ready;
   assign rx_push = rx_valid && !rx_full;
   assign rx_pop  = rd_rx && !rx_empty;

   sfi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .push_data(reg_wdata), .pop(tx_pop),
      .head(tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
   );

   sfi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .push_data(rx_data), .pop(rx_pop),
      .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
   );

   assign tx_valid = !tx_empty;

   assign thr_ok = (reg_wdata <= DW'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr <= '0;
         rx_thr <= '0;
      end else if (reg_wr && thr_ok) begin
         if (reg_addr == A_TXTHR) tx_thr <= reg_wdata[AW-1:0];
         if (reg_addr == A_RXTHR) rx_thr <= reg_wdata[AW-1:0];
      end
   end

   sfi_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_set  ({rx_valid && rx_full, rd_rx && rx_empty, wr_tx && tx_full}),
      .clr_wr   (reg_wr && (reg_addr == A_CLR)),
      .clr_bits (reg_wdata[3:0]),
      .lvl_evt  ({rx_lvl > LW'(rx_thr), tx_lvl <= LW'(tx_thr)}),
      .mask_wr  (reg_wr && (reg_addr == A_MASK)),
      .mask_in  (reg_wdata[NIRQ-1:0]),
      .raw      (irq_raw),
      .masked   (irq_msk),
      .mask_q   (irq_mask),
      .irq      (irq)
   );

   assign status = {rx_full, rx_empty, tx_empty, tx_full, eng_busy || !tx_empty};

   always_comb begin
      case (reg_addr)
         A_RXDATA:  reg_rdata = rx_empty ? '0 : rx_head;
         A_TXTHR:   reg_rdata = DW'(tx_thr);
         A_RXTHR:   reg_rdata = DW'(rx_thr);
         A_TXLVL:   reg_rdata = DW'(tx_lvl);
         A_RXLVL:   reg_rdata = DW'(rx_lvl);
         A_STAT:    reg_rdata = DW'(status);
         A_MASK:    reg_rdata = DW'(irq_mask);
         A_RAW:     reg_rdata = DW'(irq_raw);
         A_MSKSTAT: reg_rdata = DW'(irq_msk);
         default:   reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sfi_chk.sv
module sfi_chk
   import sfi_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr,
   input logic            reg_rd,
   input logic [3:0]      reg_addr,
   input logic [DW-1:0]   reg_wdata,
   input logic [DW-1:0]   reg_rdata,
   input logic            tx_valid,
   input logic            tx_ready,
   input logic            rx_valid,
   input logic            irq,
   input logic [LW-1:0]   tx_lvl,
   input logic [LW-1:0]   rx_lvl,
   input logic [NIRQ-1:0] irq_raw
);

   p_tx_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TXDATA && tx_lvl == LW'(DEPTH) && !(tx_valid && tx_ready))
      |=> (tx_lvl == LW'(DEPTH) && irq_raw[IRQ_TXOVF]));

   p_under_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_RXDATA && rx_lvl == '0) |-> (reg_rdata == '0));

   p_under_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_RXDATA && rx_lvl == '0) |=> irq_raw[IRQ_RXUND]);

   p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_lvl == LW'(DEPTH) && !(reg_rd && reg_addr == A_RXDATA))
      |=> (rx_lvl == LW'(DEPTH) && irq_raw[IRQ_RXOVF]));

   p_txovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw[IRQ_TXOVF] && !(reg_wr && reg_addr == A_CLR &&
                               (reg_wdata[CLR_ALL] || reg_wdata[CLR_TXOVF])))
      |=> irq_raw[IRQ_TXOVF]);

   p_lvl_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

   p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw == '0) |-> !irq);

endmodule

bind spi_fifo_status_irq sfi_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
   .irq(irq), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .irq_raw(irq_raw)
);

// File: tb/test_spi_fifo_status_irq.sv
module test_spi_fifo_status_irq;
   import sfi_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int DEPTH = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          tx_valid;
   logic [DW-1:0] tx_data;
   logic          tx_ready = 1'b0;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          eng_busy = 1'b0;
   logic          irq;

   spi_fifo_status_irq #(.DW(DW), .DEPTH(DEPTH)) i_spi_fifo_status_irq (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;

   // reference model
   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];
   bit m_txovf, m_rxund, m_rxovf;
   int m_txthr, m_rxthr;
   logic [4:0] m_mask;

   function automatic logic [4:0] m_raw();
      logic [4:0] r;
      r[0] = (txq.size() <= m_txthr);
      r[1] = m_txovf;
      r[2] = m_rxund;
      r[3] = m_rxovf;
      r[4] = (rxq.size() > m_rxthr);
      return r;
   endfunction

   function automatic int m_read(input logic [3:0] a);
      case (a)
         A_RXDATA:  return (rxq.size() > 0) ? int'(rxq[0]) : 0;
         A_TXTHR:   return m_txthr;
         A_RXTHR:   return m_rxthr;
         A_TXLVL:   return txq.size();
         A_RXLVL:   return rxq.size();
         A_STAT:    return {27'd0, rxq.size() == DEPTH, rxq.size() == 0, txq.size() == 0,
                            txq.size() == DEPTH, eng_busy || txq.size() != 0};
         A_MASK:    return int'(m_mask);
         A_RAW:     return int'(m_raw());
         A_MSKSTAT: return int'(m_raw() & m_mask);
         default:   return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int txn, rxn;
      bit s_tx, s_und, s_ovf;
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_txovf = 0; m_rxund = 0; m_rxovf = 0;
         m_txthr = 0; m_rxthr = 0; m_mask = '0;
      end else begin
         txn = txq.size(); rxn = rxq.size();
         s_tx = 0; s_und = 0; s_ovf = 0;
         if (tx_ready && txn > 0) void'(txq.pop_front());
         if (reg_wr && reg_addr == A_TXDATA) begin
            if (txn == DEPTH) s_tx = 1; else txq.push_back(reg_wdata);
         end
         if (reg_rd && reg_addr == A_RXDATA) begin
            if (rxn == 0) s_und = 1; else void'(rxq.pop_front());
         end
         if (rx_valid) begin
            if (rxn == DEPTH) s_ovf = 1; else rxq.push_back(rx_data);
         end
         if (reg_wr && reg_addr == A_CLR) begin
            if (reg_wdata[0] || reg_wdata[3]) m_txovf = 0;
            if (reg_wdata[0] || reg_wdata[1]) m_rxund = 0;
            if (reg_wdata[0] || reg_wdata[2]) m_rxovf = 0;
         end
         if (s_tx)  m_txovf = 1;
         if (s_und) m_rxund = 1;
         if (s_ovf) m_rxovf = 1;
         if (reg_wr && reg_addr == A_TXTHR && reg_wdata < DEPTH) m_txthr = int'(reg_wdata);
         if (reg_wr && reg_addr == A_RXTHR && reg_wdata < DEPTH) m_rxthr = int'(reg_wdata);
         if (reg_wr && reg_addr == A_MASK) m_mask = reg_wdata[4:0];
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison of state-only outputs
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 tx_valid", int'(tx_valid), int'(txq.size() > 0));
         if (txq.size() > 0) chk("R2 tx_data order", int'(tx_data), int'(txq[0]));
         chk("R11 irq line", int'(irq), int'((m_raw() & m_mask) != 0));
      end
   end

   task automatic wr(input logic [3:0] a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = DW'(d);
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1;
      chk(tag, int'(reg_rdata), m_read(a));
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, input string tag, input int exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, int'(reg_rdata), exp);
   endtask

   task automatic rx_put(input int d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = DW'(d);
      @(posedge clk); #1;
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state, R12 map
      peek(A_TXLVL, "R1 tx level", 0);
      peek(A_RXLVL, "R1 rx level", 0);
      peek(A_STAT, "R1 status", 12);
      peek(A_RAW, "R1 raw", 1);
      peek(A_MASK, "R1 mask", 0);
      chk("R1 irq", int'(irq), 0);
      peek(A_CLR, "R12 clear reads zero", 0);

      // R8 thresholds
      wr(A_TXTHR, 5);  peek(A_TXTHR, "R8 keep 5", 5);
      wr(A_TXTHR, 40); peek(A_TXTHR, "R8 reject 40", 5);
      wr(A_TXTHR, 31); peek(A_TXTHR, "R8 keep 31", 31);
      wr(A_TXTHR, 2);
      wr(A_RXTHR, 3);
      wr(A_RXTHR, 32); peek(A_RXTHR, "R8 reject 32", 3);
      wr(A_MASK, 31);  rd_chk(A_MASK, "R12 mask");

      // R2 transmit path, R9 threshold event
      wr(A_TXDATA, 16'hA1); wr(A_TXDATA, 16'hB2);
      rd_chk(A_RAW, "R9 tx at threshold");
      wr(A_TXDATA, 16'hC3);
      rd_chk(A_TXLVL, "R2 tx level");
      rd_chk(A_RAW, "R9 tx above threshold");
      rd_chk(A_STAT, "R7 busy from queue");
      @(negedge clk) tx_ready = 1'b1;
      repeat (5) @(negedge clk);
      tx_ready = 1'b0;
      rd_chk(A_RAW, "R9 tx drained");

      // R7 busy from engine
      @(negedge clk) eng_busy = 1'b1;
      peek(A_STAT, "R7 busy from engine", 13);
      @(negedge clk) eng_busy = 1'b0;

      // R3 overflow
      for (int i = 0; i < DEPTH + 1; i++) wr(A_TXDATA, 100 + i);
      peek(A_TXLVL, "R3 level stays full", DEPTH);
      rd_chk(A_STAT, "R7 tx full");
      rd_chk(A_RAW, "R3 tx overflow flag");
      wr(A_CLR, 2); rd_chk(A_RAW, "R10 unrelated clear keeps txovf");
      wr(A_CLR, 8); rd_chk(A_RAW, "R10 txovf cleared");
      @(negedge clk) tx_ready = 1'b1;
      repeat (DEPTH + 2) @(negedge clk);
      tx_ready = 1'b0;

      // R4 receive path
      for (int i = 0; i < 4; i++) rx_put(16'h500 + i);
      rd_chk(A_RXLVL, "R4 rx level");
      rd_chk(A_RAW, "R9 rx above threshold");
      for (int i = 0; i < 4; i++) rd_chk(A_RXDATA, "R4 rx data order");
      // R5 underflow
      peek(A_RXDATA, "R5 empty read zero", 0);
      rd_chk(A_RXDATA, "R5 empty read zero");
      rd_chk(A_RAW, "R5 underflow flag");

      // R6 receive overflow
      for (int i = 0; i < DEPTH + 1; i++) rx_put(16'h700 + i);
      peek(A_RXLVL, "R6 rx level full", DEPTH);
      rd_chk(A_STAT, "R7 rx full");
      rd_chk(A_RAW, "R6 rx overflow flag");
      wr(A_CLR, 4); rd_chk(A_RAW, "R10 rxovf cleared");
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 16'hDEAD;
      reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 16'd4;
      @(posedge clk); #1;
      rx_valid = 1'b0; reg_wr = 1'b0;
      rd_chk(A_RAW, "R10 set beats clear");
      for (int i = 0; i < DEPTH; i++) rd_chk(A_RXDATA, "R6 dropped word not stored");
      wr(A_CLR, 1);
      peek(A_RAW, "R10 clear all", 1);

      // R11 masking
      wr(A_MASK, 4);
      rd_chk(A_RXDATA, "R5 underflow again");
      @(negedge clk);
      chk("R11 irq masked on", int'(irq), 1);
      peek(A_MSKSTAT, "R11 masked view", 4);
      wr(A_MASK, 2);
      chk("R11 irq masked off", int'(irq), 0);
      rd_chk(A_MSKSTAT, "R11 masked view");
      wr(A_CLR, 1);

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule